// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Front End

This block sits beside a processor core and decides which hardware interrupt, if any, the core services at the next instruction boundary. It watches five request lines. One is non-maskable. Three are maskable lines with fixed vectors, named by their levels 7.5, 6.5 and 5.5. The last is a maskable external line whose handler comes from the requesting device. A global enable flip-flop and three per-line mask bits gate the maskable sources. A fixed priority picks one winner, and the block shows it together with its handler address.

The core has four operations on the block: enable, disable, load-mask and read-mask. The load-mask and read-mask operations each move a packed byte. That byte also carries a serial output bit and a sampled serial input bit. The core marks each instruction boundary with a strobe and takes the shown request by raising accept in the same cycle. For the external line the block pulses an active-low acknowledge, and the device then supplies the handler.

Top module: `irq_prio_front`

## Requirements
- R1: After reset the global enable is 0, all three mask bits are 1, the 7.5 and non-maskable latches are clear, serOut is 0 and intAckN is 1. No maskable request is shown.
- R2: Priority from highest to lowest is: non-maskable, 7.5, 6.5, 5.5, external.
- R3: The handler addresses are 0x0024 for non-maskable, 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5. irqVector is 0 whenever irqValid is 0.
- R4: The non-maskable request ignores the enable and the masks. It is taken only when a rising edge has been latched and the line is still high. Taking it clears the latch, so a line held high is not taken twice.
- R5: The 7.5, 6.5, 5.5 and external sources are shown only while the global enable is active.
- R6: An enable strobe sets the flip-flop, but the first boundary strobe after it shows no maskable source. A disable strobe closes the gate from the next cycle.
- R7: irqValid is 1 only in a cycle where boundary is 1 and an eligible source exists.
- R8: A load-mask with bit 3 set copies bits 2:0 into the masks (bit0 for 5.5, bit1 for 6.5, bit2 for 7.5). With bit 3 clear the masks are unchanged. Bit 7 is loaded into serOut only when bit 6 is 1.
- R9: A rising edge on req75 is latched and stays latched while the line is held high. The latch is cleared by taking 7.5 or by a load-mask with bit 4 set.
- R10: Lines 6.5 and 5.5 are level sensitive: dropping the line removes the request.
- R11: One cycle after a read-mask strobe, readByte holds the following: bits 2:0 the masks, bit 3 the global enable, bit 4 req55, bit 5 req65, bit 6 the 7.5 latch, bit 7 serIn.
- R12: Accepting any source clears the global enable.
- R13: An external source is shown with irqExternal 1 and vector 0. Accepting it drives intAckN low for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Non-maskable request |
| req75 | input | 1 | Edge-latched maskable request |
| req65 | input | 1 | Level maskable request |
| req55 | input | 1 | Level maskable request |
| extReq | input | 1 | Non-vectored external request |
| serIn | input | 1 | Serial input bit, returned by read-mask |
| boundary | input | 1 | Instruction boundary strobe |
| accept | input | 1 | Core takes the shown request |
| opEnable | input | 1 | Enable operation strobe |
| opDisable | input | 1 | Disable operation strobe |
| opSetMask | input | 1 | Load-mask operation strobe |
| opReadMask | input | 1 | Read-mask operation strobe |
| maskByte | input | 8 | Operand byte for load-mask |
| irqValid | output | 1 | A request is shown at this boundary |
| irqVector | output | 16 | Handler address of the shown request |
| irqExternal | output | 1 | Shown request is the external line |
| intAckN | output | 1 | Active-low acknowledge for the external line |
| readByte | output | 8 | Result of the last read-mask |
| serOut | output | 1 | Serial output bit |

## Verification
The case hardest to reach is the held-off boundary after an enable. The bench must raise enable, then show a pending source at the very next boundary and see nothing. Only at the boundary after that may the source appear. A second hard case is the 7.5 line held high across its own service: the bench accepts it without lowering the line, re-enables, and expects 6.5 to win. This shows that the latch needs a fresh edge. The non-maskable line is pulsed and dropped before a boundary, and also held high after service, to show that it needs both an edge and a held level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W = 16;

  localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_R75 = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_R65 = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_R55 = 16'h002C;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_NMI, SRC_R75, SRC_R65, SRC_R55, SRC_EXT
  } srcE;

  typedef struct packed {
    logic gateOpen;
    logic ldMask;
    logic ldSer;
    logic clr75;
    logic clrNmi;
    logic capRead;
  } strobeS;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       boundary,
  input  logic       accept,
  input  logic       opEnable,
  input  logic       opDisable,
  input  logic       opSetMask,
  input  logic       opReadMask,
  input  logic [7:0] maskByte,
  input  srcE        win,
  output strobeS     stb,
  output logic       ieFf,
  output logic       irqValid,
  output logic       intAckN
);
  logic skip;
  logic take;
  logic unusedMaskBits;

  assign unusedMaskBits = ^{maskByte[7], maskByte[5], maskByte[2:0]};

  assign irqValid = boundary && (win != SRC_NONE);
  assign take     = irqValid && accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieFf    <= 1'b0;
      skip    <= 1'b0;
      intAckN <= 1'b1;
    end else begin
      intAckN <= !(take && win == SRC_EXT);
      if (take || opDisable) begin
        ieFf <= 1'b0;
        skip <= 1'b0;
      end else if (opEnable) begin
        ieFf <= 1'b1;
        skip <= 1'b1;
      end else if (boundary) begin
        skip <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.gateOpen = ieFf && !skip;
    stb.ldMask   = opSetMask && maskByte[3];
    stb.ldSer    = opSetMask && maskByte[6];
    stb.clr75    = (opSetMask && maskByte[4]) || (take && win == SRC_R75);
    stb.clrNmi   = take && win == SRC_NMI;
    stb.capRead  = opReadMask;
  end

  AST_TAKE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rstN)
    take |=> !ieFf); // R12
  AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (!rstN)
    opDisable |=> !stb.gateOpen); // R6
  AST_ENABLE_HELD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ieFf) |-> !stb.gateOpen); // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !intAckN |=> intAckN); // R13
endmodule

// File: rtl/irq_dp.sv
module irq_dp
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeS           stb,
  input  logic             ieFf,
  input  logic             nmiReq,
  input  logic             req75,
  input  logic             req65,
  input  logic             req55,
  input  logic             extReq,
  input  logic             serIn,
  input  logic [7:0]       maskByte,
  output srcE              win,
  output logic [VEC_W-1:0] dpVector,
  output logic [7:0]       readByte,
  output logic             serOut
);
  localparam int NMASK = 3;

  logic             prevNmi, prev75, nmiEdge, lat75;
  logic [NMASK-1:0] maskQ;
  logic             riseNmi, rise75;

  assign riseNmi = nmiReq && !prevNmi;
  assign rise75  = req75 && !prev75;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevNmi  <= 1'b0;
      prev75   <= 1'b0;
      nmiEdge  <= 1'b0;
      lat75    <= 1'b0;
      maskQ    <= '1;
      serOut   <= 1'b0;
      readByte <= '0;
    end else begin
      prevNmi <= nmiReq;
      prev75  <= req75;
      if (riseNmi)         nmiEdge <= 1'b1;
      else if (stb.clrNmi) nmiEdge <= 1'b0;
      if (rise75)          lat75 <= 1'b1;
      else if (stb.clr75)  lat75 <= 1'b0;
      if (stb.ldMask)      maskQ <= maskByte[NMASK-1:0];
      if (stb.ldSer)       serOut <= maskByte[7];
      if (stb.capRead)     readByte <= {serIn, lat75, req65, req55, ieFf, maskQ};
    end
  end

  always_comb begin
    win = SRC_NONE;
    if (nmiEdge && nmiReq)                           win = SRC_NMI;
    else if (stb.gateOpen && lat75 && !maskQ[2])     win = SRC_R75;
    else if (stb.gateOpen && req65 && !maskQ[1])     win = SRC_R65;
    else if (stb.gateOpen && req55 && !maskQ[0])     win = SRC_R55;
    else if (stb.gateOpen && extReq)                 win = SRC_EXT;
  end

  always_comb begin
    unique case (win)
      SRC_NMI: dpVector = VEC_NMI;
      SRC_R75: dpVector = VEC_R75;
      SRC_R65: dpVector = VEC_R65;
      SRC_R55: dpVector = VEC_R55;
      default: dpVector = '0;
    endcase
  end

  AST_GATED_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    !stb.gateOpen |-> (win == SRC_NONE || win == SRC_NMI)); // R5
  AST_NMI_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (nmiEdge && nmiReq) |-> win == SRC_NMI); // R2
  AST_LATCH75_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (lat75 && !stb.clr75) |=> lat75); // R9
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldMask |=> $stable(maskQ)); // R8
endmodule

// File: rtl/irq_prio_front.sv
module irq_prio_front
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiReq,
  input  logic             req75,
  input  logic             req65,
  input  logic             req55,
  input  logic             extReq,
  input  logic             serIn,
  input  logic             boundary,
  input  logic             accept,
  input  logic             opEnable,
  input  logic             opDisable,
  input  logic             opSetMask,
  input  logic             opReadMask,
  input  logic [7:0]       maskByte,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector,
  output logic             irqExternal,
  output logic             intAckN,
  output logic [7:0]       readByte,
  output logic             serOut
);
  strobeS           stb;
  srcE              win;
  logic             ieFf;
  logic [VEC_W-1:0] dpVector;

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .accept(accept),
    .opEnable(opEnable), .opDisable(opDisable), .opSetMask(opSetMask),
    .opReadMask(opReadMask), .maskByte(maskByte), .win(win), .stb(stb),
    .ieFf(ieFf), .irqValid(irqValid), .intAckN(intAckN)
  );

  irq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ieFf(ieFf), .nmiReq(nmiReq),
    .req75(req75), .req65(req65), .req55(req55), .extReq(extReq),
    .serIn(serIn), .maskByte(maskByte), .win(win), .dpVector(dpVector),
    .readByte(readByte), .serOut(serOut)
  );

  assign irqVector   = irqValid ? dpVector : '0;
  assign irqExternal = irqValid && (win == SRC_EXT);

  AST_VECTOR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> irqVector == '0); // R3
endmodule

// File: tb/test_irq_prio_front.sv
module test_irq_prio_front;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiReq = 0, req75 = 0, req65 = 0, req55 = 0, extReq = 0, serIn = 0;
  logic boundary = 0, accept = 0, opEnable = 0, opDisable = 0;
  logic opSetMask = 0, opReadMask = 0;
  logic [7:0] maskByte = '0;
  logic irqValid, irqExternal, intAckN, serOut;
  logic [15:0] irqVector;
  logic [7:0] readByte;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_prio_front i_irq_prio_front (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .req75(req75), .req65(req65),
    .req55(req55), .extReq(extReq), .serIn(serIn), .boundary(boundary),
    .accept(accept), .opEnable(opEnable), .opDisable(opDisable),
    .opSetMask(opSetMask), .opReadMask(opReadMask), .maskByte(maskByte),
    .irqValid(irqValid), .irqVector(irqVector), .irqExternal(irqExternal),
    .intAckN(intAckN), .readByte(readByte), .serOut(serOut)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setMask(logic [7:0] b);
    maskByte = b; opSetMask = 1; tick(); opSetMask = 0; maskByte = '0;
  endtask

  task automatic enableIrq();
    opEnable = 1; tick(); opEnable = 0;
    boundary = 1; tick(); boundary = 0;
  endtask

  task automatic readMask(output logic [7:0] r);
    opReadMask = 1; tick(); opReadMask = 0; #1; r = readByte;
  endtask

  task automatic acceptNow();
    accept = 1; tick(); accept = 0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    #1;
    check("R1 intAckN", {15'b0, intAckN}, 16'h1);
    check("R1 serOut", {15'b0, serOut}, 16'h0);
    req65 = 1; req55 = 1; extReq = 1; boundary = 1; #1;
    check("R1 no maskable", {15'b0, irqValid}, 16'h0);
    boundary = 0; extReq = 0;
    readMask(r);
    check("R1 R11 read after reset", {8'b0, r}, 16'h0037);
    req65 = 0; req55 = 0;
  endtask

  task automatic t_enable();
    setMask(8'h08);
    req55 = 1;
    opEnable = 1; tick(); opEnable = 0;
    boundary = 1; #1;
    check("R6 first boundary held off", {15'b0, irqValid}, 16'h0);
    tick(); #1;
    check("R5 enabled 5.5 valid", {15'b0, irqValid}, 16'h1);
    check("R3 5.5 vector", irqVector, 16'h002C);
    boundary = 0; #1;
    check("R7 no boundary no valid", {15'b0, irqValid}, 16'h0);
    check("R3 idle vector zero", irqVector, 16'h0000);
    opDisable = 1; tick(); opDisable = 0;
    boundary = 1; #1;
    check("R6 disable immediate", {15'b0, irqValid}, 16'h0);
    boundary = 0; req55 = 0;
  endtask

  task automatic t_priority();
    setMask(8'h08);
    req65 = 1; req55 = 1; req75 = 1; tick();
    enableIrq();
    boundary = 1; #1;
    check("R2 7.5 wins", irqVector, 16'h003C);
    acceptNow(); #1;
    check("R12 enable cleared by accept", {15'b0, irqValid}, 16'h0);
    boundary = 0;
    enableIrq();
    boundary = 1; #1;
    check("R9 held 7.5 not retaken; R2 6.5 next", irqVector, 16'h0034);
    acceptNow(); boundary = 0;
    enableIrq();
    boundary = 1; req65 = 0; #1;
    check("R10 6.5 dropped, 5.5 wins", irqVector, 16'h002C);
    acceptNow(); boundary = 0;
    req55 = 0; req75 = 0; tick();
  endtask

  task automatic t_ext();
    extReq = 1;
    enableIrq();
    boundary = 1; #1;
    check("R13 external valid", {15'b0, irqValid}, 16'h1);
    check("R13 external flag", {15'b0, irqExternal}, 16'h1);
    check("R13 external vector", irqVector, 16'h0000);
    acceptNow(); boundary = 0; #1;
    check("R13 ack low", {15'b0, intAckN}, 16'h0);
    tick(); #1;
    check("R13 ack one cycle", {15'b0, intAckN}, 16'h1);
    extReq = 0;
  endtask

  task automatic t_mask();
    logic [7:0] r;
    setMask(8'h0A);
    req65 = 1; req55 = 1;
    enableIrq();
    boundary = 1; #1;
    check("R8 6.5 masked, 5.5 wins", irqVector, 16'h002C);
    boundary = 0;
    setMask(8'h05);
    serIn = 1;
    readMask(r);
    check("R8 R11 masks kept without bit3", {8'b0, r}, 16'h00BA);
    req75 = 1; tick();
    readMask(r);
    check("R9 R11 7.5 latched", {8'b0, r}, 16'h00FA);
    setMask(8'h10);
    readMask(r);
    check("R9 bit4 clears 7.5 latch", {8'b0, r}, 16'h00BA);
    req75 = 0;
    setMask(8'hC0); #1;
    check("R8 serial set", {15'b0, serOut}, 16'h1);
    setMask(8'h80); #1;
    check("R8 serial kept without bit6", {15'b0, serOut}, 16'h1);
    setMask(8'h40); #1;
    check("R8 serial cleared", {15'b0, serOut}, 16'h0);
    opDisable = 1; tick(); opDisable = 0;
    req65 = 0; req55 = 0; serIn = 0;
  endtask

  task automatic t_nmi();
    setMask(8'h0F);
    nmiReq = 1; tick();
    boundary = 1; #1;
    check("R4 nmi ignores enable and masks", irqVector, 16'h0024);
    acceptNow(); #1;
    check("R4 held nmi not retaken", {15'b0, irqValid}, 16'h0);
    boundary = 0;
    nmiReq = 0; tick(); nmiReq = 1; tick(); nmiReq = 0; tick();
    boundary = 1; #1;
    check("R4 nmi pulse gone not taken", {15'b0, irqValid}, 16'h0);
    boundary = 0;
    setMask(8'h08);
    req75 = 1; tick();
    enableIrq();
    nmiReq = 1; tick();
    boundary = 1; #1;
    check("R2 nmi above 7.5", irqVector, 16'h0024);
    acceptNow(); boundary = 0; nmiReq = 0; req75 = 0; tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    t_reset();
    t_enable();
    t_priority();
    t_ext();
    t_mask();
    t_nmi();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule